// File: doc/BRIEF.md
# Configurable-Select Synchronous Serial Port

This block is a full-duplex, byte-wide synchronous serial port. It can act as the bus master, generating the serial clock, or as a slave, following an external clock. A small register bus, with an address, a write strobe, a read strobe and 8-bit data, programs the port. Through it software sets the role, the clock polarity and phase, and the master bit-rate divider. It also writes bytes to transmit and reads bytes received. Outgoing bytes wait in a one-entry transmit holding register. Incoming bytes are placed in a one-entry receive holding register. A single shift engine sits between the two and shifts out and in on the same clock edges.

The slave-select pin has four roles:
- Ignored (three-wire operation).
- An active-low select input when the port is a slave.
- A contention sense input when the port is a master. Another master pulling it low forces this port out of the master role and records a mode fault.
- A chip-select output, driven from a register bit while the port is master.

One interrupt line reports completion, write collision, receive overrun and mode fault.

Top module: `spi_port`

Register map (bus address → meaning):
- Address 0, control:
  - bit0 enables the port.
  - bits2:1 set the select role: 00 ignored, 01 input, 10 output, 11 treated as ignored.
  - bit3 is the select output level.
  - Status flags: bit4 transfer done, bit5 write collision, bit6 overrun, bit7 mode fault. Writing 1 to a flag bit clears it.
- Address 1, configuration:
  - bit0 selects master, bit1 sets clock polarity, bit2 sets clock phase.
  - Read-only status: bit5 receive holding full, bit6 transmit holding full, bit7 busy.
- Address 2: bit-rate divider.
- Address 3: data. A write loads the transmit holding register. A read returns the receive holding register and empties it.

## Requirements
- R1: After reset every register reads 0, the interrupt is low and the sck_oe, mosi_oe, miso_oe and nss_oe outputs are all low.
- R2: In master mode, a byte written to address 3 is shifted out on mosi_o most significant bit first, and the bits sampled from miso_i are collected at the same time. At the end of the byte, the received value is readable at address 3 and control bit4 is set.
- R3: While a master transfer runs, each level of sck_o lasts exactly divider+1 system clocks.
- R4: The master sck_o rests at the polarity bit when idle. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge of each bit.
- R5: Configuration bit7 (busy) rises one clock after a byte leaves the transmit holding register. It stays high for 16×(divider+1) clocks in master mode.
- R6: A write to address 3 while the transmit holding register is full sets control bit5, and the written byte is discarded.
- R7: A byte that completes while the receive holding register is full sets control bit6. The older byte is kept.
- R8: With select role 00 a master never drives the select pin (nss_oe low), and a slave is always selected.
- R9: With select role 01 a slave drives miso_oe and counts clock edges only while nss_i is low. Clock edges with nss_i high complete no byte.
- R10: With select role 01, nss_i low while the port is master clears configuration bit0, sets control bit7, and drops sck_oe.
- R11: With select role 10 and master mode, nss_oe is high and nss_o equals control bit3.
- R12: irq is high exactly when the port is enabled and any of control bits 7:4 is set. Writing 1 to a flag bit clears it.
- R13: In slave mode the port samples mosi_i on the edges given by the polarity and phase bits. It shifts its transmit byte out on miso_o, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (empties receive holding on address 3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Event interrupt |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data input in slave mode |
| mosi_o | output | 1 | Serial data output in master mode |
| mosi_oe | output | 1 | mosi_o enable |
| miso_i | input | 1 | Serial data input in master mode |
| miso_o | output | 1 | Serial data output in slave mode |
| miso_oe | output | 1 | miso_o enable |
| nss_i | input | 1 | Slave-select / contention input |
| nss_o | output | 1 | Chip-select output level |
| nss_oe | output | 1 | Chip-select output enable |

## Verification
The bench builds the port with its default 8-bit data and 8-bit divider widths. It programs divider values 0 to 3, so every combination of polarity and phase completes a byte in a few dozen clocks. With those values the exact half-period count and the busy length can be checked against divider+1 and 16×(divider+1). Slave operation is driven at a slow bench-generated clock, well above the input synchronizer latency. This makes select gating, the mode-fault takeover and the collision and overrun flags observable through the register bus.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        NSS_OFF  = 2'b00,
        NSS_IN   = 2'b01,
        NSS_OUT  = 2'b10,
        NSS_RSVD = 2'b11
    } nss_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_CFG  = 2'd1,
        A_RATE = 2'd2,
        A_DATA = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              en;
        nss_mode_e         mode;
        logic              nss_lvl;
        logic              master;
        logic              cpol;
        logic              cpha;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] tx;
        logic              tx_full;
        logic [DATA_W-1:0] rx;
        logic              rx_full;
        logic              f_done;
        logic              f_wcol;
        logic              f_ovr;
        logic              f_modf;
    } regs_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int            W       = 3,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stg_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= {2{RST_VAL[i]}};
            else        stg_q <= {stg_q[0], din[i]};
        end
        assign dout[i] = stg_q[1];
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DW   = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            master,
    input  logic            cpol,
    input  logic            cpha,
    input  logic [DIVW-1:0] div,
    input  logic            slave_sel,
    input  logic            sck_s,
    input  logic            din_s,
    input  logic            miso_i,
    input  logic            abort,
    input  logic            load,
    input  logic [DW-1:0]   tx_byte,
    output logic            take,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rx_byte,
    output logic            sck_o,
    output logic            dout
);
    localparam int             EW    = $clog2(2 * DW);
    localparam logic [EW-1:0]  ELAST = EW'(2 * DW - 1);

    typedef struct packed {
        logic [DW-1:0]   sh;
        logic [DW-1:0]   rs;
        logic [EW-1:0]   e;
        logic            busy;
        logic            sck;
        logic            mout;
        logic [DIVW-1:0] cnt;
        logic            sck_prev;
    } eng_t;

    eng_t q, d;
    logic edge_c;

    always_comb begin
        d        = q;
        take     = 1'b0;
        done     = 1'b0;
        edge_c   = 1'b0;
        d.sck_prev = sck_s;
        if (!en || abort) begin
            d.busy = 1'b0;
            d.e    = '0;
            d.cnt  = '0;
            d.sck  = cpol;
        end else if (master) begin
            if (!q.busy) begin
                d.cnt = '0;
                d.sck = cpol;
                d.e   = '0;
                if (load) begin
                    d.sh   = tx_byte;
                    d.busy = 1'b1;
                    take   = 1'b1;
                end
            end else if (q.cnt == div) begin
                d.cnt  = '0;
                d.sck  = ~q.sck;
                edge_c = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.sck = cpol;
            d.cnt = '0;
            if (!slave_sel) d.e = '0;
            else            edge_c = (sck_s != q.sck_prev);
            if (!q.busy && q.e == '0 && load && !edge_c) begin
                d.sh   = tx_byte;
                d.busy = 1'b1;
                take   = 1'b1;
            end
        end
        if (edge_c) begin
            if (q.e[0] == cpha) begin
                d.rs = {q.rs[DW-2:0], master ? miso_i : din_s};
            end else begin
                if (cpha) d.mout = q.sh[DW-1];
                d.sh = {q.sh[DW-2:0], 1'b0};
            end
            if (q.e == ELAST) begin
                done   = 1'b1;
                d.busy = 1'b0;
                d.e    = '0;
            end else begin
                d.e = q.e + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign rx_byte = d.rs;
    assign sck_o   = q.sck;
    assign dout    = cpha ? q.mout : q.sh[DW-1];

    // R4: a master at rest holds its clock at the polarity level
    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !q.busy && $past(en && master && !q.busy) && $stable(cpol))
        |-> (q.sck == cpol));

    // R3: between divider terminal counts the serial clock level is held
    a_r3_half_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !abort && q.busy && q.cnt != div) |=> $stable(q.sck));
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              nss_s,
    input  logic              take,
    input  logic              done,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              en,
    output logic              master,
    output logic              cpol,
    output logic              cpha,
    output nss_mode_e         mode,
    output logic              nss_lvl,
    output logic [DIV_W-1:0]  div,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_full,
    output logic              fault
);
    regs_t q, d;
    logic  rd_data;

    always_comb begin
        d       = q;
        rd_data = bus_rd && (bus_addr == A_DATA);
        fault   = q.en && q.master && (q.mode == NSS_IN) && !nss_s;
        if (take) d.tx_full = 1'b0;
        if (rd_data) d.rx_full = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    d.en      = bus_wdata[0];
                    d.mode    = nss_mode_e'(bus_wdata[2:1]);
                    d.nss_lvl = bus_wdata[3];
                    if (bus_wdata[4]) d.f_done = 1'b0;
                    if (bus_wdata[5]) d.f_wcol = 1'b0;
                    if (bus_wdata[6]) d.f_ovr  = 1'b0;
                    if (bus_wdata[7]) d.f_modf = 1'b0;
                end
                A_CFG: begin
                    d.master = bus_wdata[0];
                    d.cpol   = bus_wdata[1];
                    d.cpha   = bus_wdata[2];
                end
                A_RATE: d.div = bus_wdata;
                default: begin
                    if (q.tx_full) begin
                        d.f_wcol = 1'b1;
                    end else begin
                        d.tx      = bus_wdata;
                        d.tx_full = 1'b1;
                    end
                end
            endcase
        end
        if (done) begin
            d.f_done = 1'b1;
            if (q.rx_full && !rd_data) begin
                d.f_ovr = 1'b1;
            end else begin
                d.rx      = rx_byte;
                d.rx_full = 1'b1;
            end
        end
        if (fault) begin
            d.master = 1'b0;
            d.f_modf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {q.f_modf, q.f_ovr, q.f_wcol, q.f_done,
                                  q.nss_lvl, q.mode, q.en};
            A_CFG:   bus_rdata = {busy, q.tx_full, q.rx_full, 2'b00,
                                  q.cpha, q.cpol, q.master};
            A_RATE:  bus_rdata = q.div;
            default: bus_rdata = q.rx;
        endcase
    end

    assign irq     = q.en && (q.f_done || q.f_wcol || q.f_ovr || q.f_modf);
    assign en      = q.en;
    assign master  = q.master;
    assign cpol    = q.cpol;
    assign cpha    = q.cpha;
    assign mode    = q.mode;
    assign nss_lvl = q.nss_lvl;
    assign div     = q.div;
    assign tx_byte = q.tx;
    assign tx_full = q.tx_full;

    // R6: a data write into a full transmit holding register flags and drops
    a_r6_wcol_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA && q.tx_full) |=> (q.f_wcol && $stable(q.tx)));

    // R7: completion into a full receive holding register keeps the old byte
    a_r7_overrun_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.rx_full && !rd_data) |=> (q.f_ovr && $stable(q.rx)));

    // R10: contention on the select input removes the master role
    a_r10_mode_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!q.master && q.f_modf));

    // R5: the shift engine reports busy right after it accepts a byte
    a_r5_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fault && en) |=> busy);
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              nss_i,
    output logic              nss_o,
    output logic              nss_oe
);
    logic [2:0]        sync_out;
    logic              sck_s, din_s, nss_s;
    logic              en, master, cpol, cpha, nss_lvl, tx_full, fault;
    nss_mode_e         mode;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] tx_byte, rx_byte;
    logic              take, busy, done, slave_sel, dout;

    spi_in_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({nss_i, mosi_i, sck_i}),
        .dout(sync_out)
    );
    assign {nss_s, din_s, sck_s} = sync_out;

    spi_reg_file u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .nss_s(nss_s), .take(take), .done(done), .busy(busy),
        .rx_byte(rx_byte), .en(en), .master(master), .cpol(cpol),
        .cpha(cpha), .mode(mode), .nss_lvl(nss_lvl), .div(div),
        .tx_byte(tx_byte), .tx_full(tx_full), .fault(fault)
    );

    assign slave_sel = (mode != NSS_IN) || !nss_s;

    spi_shift_engine #(.DW(DATA_W), .DIVW(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(en), .master(master),
        .cpol(cpol), .cpha(cpha), .div(div), .slave_sel(slave_sel),
        .sck_s(sck_s), .din_s(din_s), .miso_i(miso_i), .abort(fault),
        .load(tx_full), .tx_byte(tx_byte), .take(take), .busy(busy),
        .done(done), .rx_byte(rx_byte), .sck_o(sck_o), .dout(dout)
    );

    assign sck_oe  = en && master;
    assign mosi_o  = dout;
    assign mosi_oe = en && master;
    assign miso_o  = dout;
    assign miso_oe = en && !master && slave_sel;
    assign nss_o   = nss_lvl;
    assign nss_oe  = en && master && (mode == NSS_OUT);
endmodule

// File: tb/tb_spi_port.sv
module tb_spi_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    logic       sck_b = 1'b0, mosi_b = 1'b0, nss_b = 1'b1;
    logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, nss_o, nss_oe;
    logic       miso_i;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    assign miso_i = mosi_o;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq),
        .sck_i(sck_b), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_b), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .nss_i(nss_b), .nss_o(nss_o), .nss_oe(nss_oe)
    );

    // {tx, divider, cpol, cpha}
    localparam logic [17:0] VEC [6] = '{
        {8'hA5, 8'd0, 1'b0, 1'b0},
        {8'h3C, 8'd1, 1'b0, 1'b1},
        {8'h81, 8'd2, 1'b1, 1'b0},
        {8'h7E, 8'd0, 1'b1, 1'b1},
        {8'hF0, 8'd3, 1'b0, 1'b0},
        {8'h0F, 8'd1, 1'b1, 1'b1}
    };

    // master-side line monitor
    logic       mon_on = 1'b0, cur_cpol = 1'b0, cur_cpha = 1'b0;
    logic [7:0] cur_div = 8'd0, cap = 8'd0;
    logic       sck_prev = 1'b0, seen_toggle = 1'b0;
    int         hp = 0, hp_bad = 0, busy_cnt = 0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (addr == 2'd1 && rdata[7]) busy_cnt++;
            if (sck_o != sck_prev) begin
                if (seen_toggle && (hp + 1) != (int'(cur_div) + 1)) hp_bad++;
                seen_toggle = 1'b1;
                hp = 0;
                if (((sck_o != cur_cpol) && !cur_cpha) ||
                    ((sck_o == cur_cpol) && cur_cpha))
                    cap = {cap[6:0], mosi_o};
            end else begin
                hp++;
            end
        end
        sck_prev = sck_o;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_irq(input int max);
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        peek(2'd0, v); chk("R1 ctrl", v, 8'h00);
        peek(2'd1, v); chk("R1 cfg", v, 8'h00);
        peek(2'd2, v); chk("R1 rate", v, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 oe", {sck_oe, mosi_oe, miso_oe, nss_oe}, 4'b0000);

        // R2 R3 R4 R5: table-driven master loopback transfers
        foreach (VEC[k]) begin
            logic [7:0] txv, dv;
            logic       pol, pha;
            {txv, dv, pol, pha} = VEC[k];
            bus_write(2'd1, {5'b0, pha, pol, 1'b1});
            bus_write(2'd2, dv);
            bus_write(2'd0, 8'hF1);
            idle(3);
            chk("R4 idle sck level", sck_o, pol);
            cur_cpol = pol; cur_cpha = pha; cur_div = dv;
            cap = 8'h00; hp = 0; hp_bad = 0; busy_cnt = 0; seen_toggle = 1'b0;
            sck_prev = sck_o;
            mon_on = 1'b1;
            bus_write(2'd3, txv);
            addr = 2'd1;
            wait_irq(200);
            idle(2);
            mon_on = 1'b0;
            chk("R2 mosi msb-first", cap, txv);
            chk("R3 half period", hp_bad, 0);
            chk("R5 busy length", busy_cnt, 16 * (int'(dv) + 1));
            chk("R4 sck back to idle", sck_o, pol);
            peek(2'd0, v); chk("R2 done flag", v[4], 1'b1);
            bus_read(2'd3, v); chk("R2 received byte", v, txv);
        end

        // R8: three-wire master does not drive the select pin
        bus_write(2'd0, 8'hF1);
        idle(2);
        chk("R8 nss_oe in 3-wire", nss_oe, 1'b0);

        // R11: chip-select output follows the level bit
        bus_write(2'd0, 8'hF5);
        idle(1);
        chk("R11 nss_oe", nss_oe, 1'b1);
        chk("R11 nss_o low", nss_o, 1'b0);
        bus_write(2'd0, 8'hFD);
        idle(1);
        chk("R11 nss_o high", nss_o, 1'b1);

        // R6 R7: collision and overrun
        bus_write(2'd1, 8'h01);
        bus_write(2'd2, 8'd1);
        bus_write(2'd0, 8'hF1);
        bus_write(2'd3, 8'h11);
        idle(3);
        bus_write(2'd3, 8'h22);
        bus_write(2'd3, 8'h33);
        idle(100);
        peek(2'd0, v);
        chk("R6 wcol flag", v[5], 1'b1);
        chk("R7 ovr flag", v[6], 1'b1);
        bus_read(2'd3, v); chk("R7 old byte kept", v, 8'h11);
        peek(2'd1, v); chk("R6 third byte dropped", v[7:6], 2'b00);

        // R12: write-one-to-clear
        bus_write(2'd0, 8'hF1);
        idle(1);
        chk("R12 irq after clear", irq, 1'b0);

        // R9 R13: four-wire slave, cpol 0 cpha 0
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'hF3);
        bus_write(2'd3, 8'hA5);
        idle(4);
        chk("R9 miso_oe while deselected", miso_oe, 1'b0);
        nss_b = 1'b0;
        idle(4);
        chk("R9 miso_oe while selected", miso_oe, 1'b1);
        begin
            logic [7:0] mb, got;
            mb = 8'h3C; got = 8'h00;
            for (int i = 7; i >= 0; i--) begin
                mosi_b = mb[i];
                idle(8);
                got = {got[6:0], miso_o};
                sck_b = 1'b1;
                idle(8);
                sck_b = 1'b0;
            end
            idle(8);
            chk("R13 slave miso msb-first", got, 8'hA5);
            chk("R13 slave irq", irq, 1'b1);
            bus_read(2'd3, v); chk("R13 slave received", v, mb);
        end
        nss_b = 1'b1;
        bus_write(2'd0, 8'hF3);
        idle(4);
        for (int i = 0; i < 8; i++) begin
            sck_b = 1'b1; idle(6);
            sck_b = 1'b0; idle(6);
        end
        idle(4);
        peek(2'd0, v); chk("R9 no byte while deselected", v[4], 1'b0);
        chk("R9 miso_oe off", miso_oe, 1'b0);

        // R8: three-wire slave is always selected
        bus_write(2'd0, 8'hF1);
        idle(2);
        chk("R8 slave selected in 3-wire", miso_oe, 1'b1);

        // R10: contention on the select input as master
        bus_write(2'd1, 8'h01);
        bus_write(2'd0, 8'hF3);
        idle(4);
        chk("R10 master before fault", sck_oe, 1'b1);
        nss_b = 1'b0;
        idle(6);
        peek(2'd1, v); chk("R10 master cleared", v[0], 1'b0);
        peek(2'd0, v); chk("R10 modf flag", v[7], 1'b1);
        chk("R10 sck_oe dropped", sck_oe, 1'b0);
        chk("R12 irq on fault", irq, 1'b1);
        bus_write(2'd0, 8'h83);
        idle(1);
        peek(2'd0, v); chk("R12 modf cleared", v[7], 1'b0);
        chk("R12 irq cleared", irq, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule